// File: doc/BRIEF.md
# Programmable Panel Timing Output Generator

This block drives a bank of general-purpose timing strobes for a display timing controller. A free-running pixel counter and a line counter follow the incoming line and frame sync pulses. Each strobe is asserted when the pixel position falls inside its programmed horizontal span and the line position falls inside its programmed vertical span. A per-strobe control word selects active-high or active-low output. It can also switch the strobe into an alternating mode, in which it produces a level that flips from line to line. That mode is intended for polarity-reversal signals.

In alternating mode, the level flips at every line start that closes a line inside the strobe's vertical span. So when the programmed vertical span has an odd number of lines, the level also swaps from one frame to the next. The flip state is never cleared at frame start. Strobe 0 can also drive a pixel-data line-inversion flag. The last strobe (index 9) defines the output blanking window: data is blanked whenever that strobe's decoded level is inactive. All outputs are registered.

Top module: `panel_gpo_gen`

## Requirements
- R1: While rst_ni is low, gpo_o is all zeros, line_inv_o is 0 and blank_o is 1.
- R2: A line_sync_i pulse clears the pixel counter to 0 and adds one to the line counter. In all other cycles without a sync pulse, the pixel counter adds one.
- R3: With control bits 1:0 = 00, strobe n is driven high in the cycle after the counters satisfy hstart <= pixel < hstop and vstart <= line < vstart + vdur.
- R4: Control bit 0 = 1 inverts the strobe level after the window decode, making the strobe active low.
- R5: Control bit 1 = 1 selects alternating mode: the strobe's decoded level equals a per-strobe flip state. That state inverts at each line start whose preceding line lay inside the strobe's vertical span, and it is left unchanged by frame_sync_i.
- R6: In alternating mode, an odd vdur makes the level seen at the start of each frame swap from frame to frame, and an even vdur keeps it the same.
- R7: line_inv_o is registered and equals strobe 0's decoded level (before polarity) when control bit 2 of strobe 0 is 1; otherwise it is 0.
- R8: blank_o is registered and equals the inverse of strobe 9's decoded level (before polarity).
- R9: A register write uses address {index[6:3], field[2:0]} with field codes 0 = hstart, 1 = hstop, 2 = vstart, 3 = vdur, 4 = control. The new value is used from the clock edge after the write. Writes with an index of 10 or more, or a field code of 5 to 7, change nothing.
- R10: A frame_sync_i pulse clears both counters to 0 and counts as a line start for R5, including when it arrives in the middle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_sync_i | input | 1 | One-cycle pulse at the start of each line |
| frame_sync_i | input | 1 | One-cycle pulse at the start of each frame (also starts a line) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Write address {strobe index, field code} |
| reg_wdata_i | input | 11 | Write data |
| gpo_o | output | 10 | Timing strobe vector |
| line_inv_o | output | 1 | Pixel data line-inversion flag |
| blank_o | output | 1 | Output blanking flag |

## Verification
The risky coincidence is a line start, which clears the pixel counter and flips the alternating state, landing in the same cycle as either a window edge at pixel 0 or a register write. Strobe 0 is given a window that opens at pixel 0. Register writes are also issued in the very cycle that carries line_sync_i or frame_sync_i. A cycle-accurate scoreboard model judges each case. That model applies the old register values and the old line count for the coinciding edge and the new ones after it, and every registered output is compared on every cycle.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int unsigned FLD_W  = 3;
  localparam int unsigned CTRL_POL  = 0;
  localparam int unsigned CTRL_TGL  = 1;
  localparam int unsigned CTRL_LINV = 2;

  typedef enum logic [FLD_W-1:0] {
    FLD_HSTART = 3'd0,
    FLD_HSTOP  = 3'd1,
    FLD_VSTART = 3'd2,
    FLD_VDUR   = 3'd3,
    FLD_CTRL   = 3'd4
  } fld_e;
endpackage

// File: rtl/gpo_timebase.sv
module gpo_timebase #(
  parameter int unsigned HCNT_W = 11,
  parameter int unsigned VCNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              frame_sync_i,
  output logic              line_start_o,
  output logic [HCNT_W-1:0] h_cnt_o,
  output logic [VCNT_W-1:0] v_cnt_o
);
  assign line_start_o = line_sync_i | frame_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_o <= '0;
      v_cnt_o <= '0;
    end else if (frame_sync_i) begin
      h_cnt_o <= '0;
      v_cnt_o <= '0;
    end else if (line_sync_i) begin
      h_cnt_o <= '0;
      v_cnt_o <= v_cnt_o + 1'b1;
    end else begin
      h_cnt_o <= h_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/gpo_regs.sv
module gpo_regs
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 10,
  parameter int unsigned HCNT_W   = 11,
  parameter int unsigned VCNT_W   = 11,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned DATA_W   = 11,
  parameter int unsigned LINV_IDX = 0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W+FLD_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_OUT-1:0][HCNT_W-1:0] hstart_o,
  output logic [NUM_OUT-1:0][HCNT_W-1:0] hstop_o,
  output logic [NUM_OUT-1:0][VCNT_W-1:0] vstart_o,
  output logic [NUM_OUT-1:0][VCNT_W-1:0] vdur_o,
  output logic [NUM_OUT-1:0]             pol_o,
  output logic [NUM_OUT-1:0]             tgl_en_o,
  output logic                           linv_en_o
);
  logic [IDX_W-1:0] wr_idx;
  fld_e             wr_fld;

  assign wr_idx = addr_i[IDX_W+FLD_W-1:FLD_W];
  assign wr_fld = fld_e'(addr_i[FLD_W-1:0]);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_bank
    logic              sel;
    logic [HCNT_W-1:0] hs_q, he_q;
    logic [VCNT_W-1:0] vs_q, vd_q;
    logic              pol_q, tgl_q;

    assign sel = we_i && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hs_q  <= '0;
        he_q  <= '0;
        vs_q  <= '0;
        vd_q  <= '0;
        pol_q <= 1'b0;
        tgl_q <= 1'b0;
      end else if (sel) begin
        case (wr_fld)
          FLD_HSTART: hs_q <= wdata_i[HCNT_W-1:0];
          FLD_HSTOP:  he_q <= wdata_i[HCNT_W-1:0];
          FLD_VSTART: vs_q <= wdata_i[VCNT_W-1:0];
          FLD_VDUR:   vd_q <= wdata_i[VCNT_W-1:0];
          FLD_CTRL: begin
            pol_q <= wdata_i[CTRL_POL];
            tgl_q <= wdata_i[CTRL_TGL];
          end
          default: ;
        endcase
      end
    end

    assign hstart_o[g] = hs_q;
    assign hstop_o[g]  = he_q;
    assign vstart_o[g] = vs_q;
    assign vdur_o[g]   = vd_q;
    assign pol_o[g]    = pol_q;
    assign tgl_en_o[g] = tgl_q;

    if (g == LINV_IDX) begin : g_linv
      logic linv_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      linv_q <= 1'b0;
        else if (sel && wr_fld == FLD_CTRL) linv_q <= wdata_i[CTRL_LINV];
      end
      assign linv_en_o = linv_q;
    end
  end
endmodule

// File: rtl/gpo_channel.sv
module gpo_channel #(
  parameter int unsigned HCNT_W = 11,
  parameter int unsigned VCNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [HCNT_W-1:0] h_cnt_i,
  input  logic [VCNT_W-1:0] v_cnt_i,
  input  logic [HCNT_W-1:0] hstart_i,
  input  logic [HCNT_W-1:0] hstop_i,
  input  logic [VCNT_W-1:0] vstart_i,
  input  logic [VCNT_W-1:0] vdur_i,
  input  logic              pol_i,
  input  logic              tgl_en_i,
  output logic              pre_o,
  output logic              tgl_o,
  output logic              gpo_o
);
  logic            h_win, v_win;
  logic [VCNT_W:0] v_end;
  logic            tgl_q;

  assign v_end = {1'b0, vstart_i} + {1'b0, vdur_i};
  assign h_win = (h_cnt_i >= hstart_i) && (h_cnt_i < hstop_i);
  assign v_win = ({1'b0, v_cnt_i} >= {1'b0, vstart_i}) && ({1'b0, v_cnt_i} < v_end);

  // flip state only counts lines inside the vertical span; frame sync does not clear it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tgl_q <= 1'b0;
    else if (line_start_i && v_win) tgl_q <= ~tgl_q;
  end

  assign pre_o = tgl_en_i ? tgl_q : (h_win && v_win);
  assign tgl_o = tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpo_o <= 1'b0;
    else         gpo_o <= pre_o ^ pol_i;
  end
endmodule

// File: rtl/panel_gpo_gen.sv
module panel_gpo_gen
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_OUT = 10,
  parameter int unsigned HCNT_W  = 11,
  parameter int unsigned VCNT_W  = 11,
  localparam int unsigned IDX_W  = $clog2(NUM_OUT),
  localparam int unsigned ADDR_W = IDX_W + FLD_W,
  localparam int unsigned DATA_W = (HCNT_W > VCNT_W) ? HCNT_W : VCNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_sync_i,
  input  logic               frame_sync_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [NUM_OUT-1:0] gpo_o,
  output logic               line_inv_o,
  output logic               blank_o
);
  localparam int unsigned LINV_IDX  = 0;
  localparam int unsigned BLANK_IDX = NUM_OUT - 1;

  logic                           line_start;
  logic [HCNT_W-1:0]              h_cnt;
  logic [VCNT_W-1:0]              v_cnt;
  logic [NUM_OUT-1:0][HCNT_W-1:0] hstart, hstop;
  logic [NUM_OUT-1:0][VCNT_W-1:0] vstart, vdur;
  logic [NUM_OUT-1:0]             pol_vec, tgl_en, pre_vec, tgl_vec;
  logic                           linv_en;

  gpo_timebase #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_tb (
    .clk_i, .rst_ni, .line_sync_i, .frame_sync_i,
    .line_start_o(line_start), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt)
  );

  gpo_regs #(
    .NUM_OUT(NUM_OUT), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W),
    .IDX_W(IDX_W), .DATA_W(DATA_W), .LINV_IDX(LINV_IDX)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .hstart_o(hstart), .hstop_o(hstop), .vstart_o(vstart), .vdur_o(vdur),
    .pol_o(pol_vec), .tgl_en_o(tgl_en), .linv_en_o(linv_en)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
    gpo_channel #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_ch (
      .clk_i, .rst_ni,
      .line_start_i(line_start), .h_cnt_i(h_cnt), .v_cnt_i(v_cnt),
      .hstart_i(hstart[g]), .hstop_i(hstop[g]),
      .vstart_i(vstart[g]), .vdur_i(vdur[g]),
      .pol_i(pol_vec[g]), .tgl_en_i(tgl_en[g]),
      .pre_o(pre_vec[g]), .tgl_o(tgl_vec[g]), .gpo_o(gpo_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_inv_o <= 1'b0;
      blank_o    <= 1'b1;
    end else begin
      line_inv_o <= linv_en & pre_vec[LINV_IDX];
      blank_o    <= ~pre_vec[BLANK_IDX];
    end
  end
endmodule

// File: rtl/panel_gpo_gen_chk.sv
module panel_gpo_gen_chk #(
  parameter int unsigned NUM_OUT = 10,
  parameter int unsigned HCNT_W  = 11,
  parameter int unsigned VCNT_W  = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               line_sync_i,
  input logic               frame_sync_i,
  input logic               line_start,
  input logic [HCNT_W-1:0]  h_cnt,
  input logic [VCNT_W-1:0]  v_cnt,
  input logic [NUM_OUT-1:0] tgl_vec,
  input logic [NUM_OUT-1:0] pol_vec,
  input logic               linv_en,
  input logic [NUM_OUT-1:0] gpo_o,
  input logic               line_inv_o,
  input logic               blank_o
);
  AST_HCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start |=> (h_cnt == '0)); // R2
  AST_HCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start |=> (h_cnt == $past(h_cnt) + 1'b1)); // R2
  AST_VCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_sync_i && !frame_sync_i) |=> (v_cnt == $past(v_cnt) + 1'b1)); // R2
  AST_VCNT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> (v_cnt == '0 && h_cnt == '0)); // R10
  AST_TGL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start |=> $stable(tgl_vec)); // R5
  AST_LINV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !linv_en |=> !line_inv_o); // R7
  AST_BLANK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pol_vec[NUM_OUT-1]) |-> (blank_o != gpo_o[NUM_OUT-1])); // R8
endmodule

bind panel_gpo_gen panel_gpo_gen_chk #(
  .NUM_OUT(NUM_OUT), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .line_sync_i(line_sync_i), .frame_sync_i(frame_sync_i),
  .line_start(line_start), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .tgl_vec(tgl_vec), .pol_vec(pol_vec), .linv_en(linv_en),
  .gpo_o(gpo_o), .line_inv_o(line_inv_o), .blank_o(blank_o)
);

// File: tb/panel_gpo_gen_tb_top.sv
module panel_gpo_gen_tb_top;
  localparam int NO = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          line_sync_i = 1'b0;
  logic          frame_sync_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [6:0]    reg_addr_i = '0;
  logic [10:0]   reg_wdata_i = '0;
  logic [NO-1:0] gpo_o;
  logic          line_inv_o;
  logic          blank_o;

  int tests_run = 0;
  int tests_failed = 0;
  int cyc = 0;
  string phase = "R1";

  always #5 clk_i = ~clk_i;

  panel_gpo_gen dut_i (
    .clk_i, .rst_ni, .line_sync_i, .frame_sync_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .gpo_o, .line_inv_o, .blank_o
  );

  typedef struct {
    logic [NO-1:0] g;
    logic          li;
    logic          bl;
  } exp_t;
  exp_t sb_q[$];

  // reference model state, built from the requirements
  int mh, mv;
  int hs[NO], he[NO], vs[NO], vd[NO];
  bit pol[NO], te[NO], tg[NO];
  bit linv;

  task automatic chk(string req, string what, logic [NO-1:0] act, logic [NO-1:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s (phase %s): actual %b expected %b", req, what, phase, act, exp);
    end
  endtask

  // model: compute expected registered outputs for this edge, then advance state
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mh = 0; mv = 0; linv = 0;
      for (int i = 0; i < NO; i++) begin
        hs[i] = 0; he[i] = 0; vs[i] = 0; vd[i] = 0;
        pol[i] = 0; te[i] = 0; tg[i] = 0;
      end
    end else begin
      exp_t e;
      bit vw[NO];
      bit pre[NO];
      for (int i = 0; i < NO; i++) begin
        bit hw;
        hw = (mh >= hs[i]) && (mh < he[i]);
        vw[i] = (mv >= vs[i]) && (mv < vs[i] + vd[i]);
        pre[i] = te[i] ? tg[i] : (hw && vw[i]);
        e.g[i] = pre[i] ^ pol[i];
      end
      e.li = linv && pre[0];
      e.bl = !pre[NO-1];
      sb_q.push_back(e);
      if (line_sync_i || frame_sync_i) begin
        for (int i = 0; i < NO; i++) if (vw[i]) tg[i] = !tg[i];
        mh = 0;
        mv = frame_sync_i ? 0 : (mv + 1) % 2048;
      end else begin
        mh = (mh + 1) % 2048;
      end
      if (reg_we_i) begin
        int idx, f, d;
        idx = int'(reg_addr_i[6:3]);
        f   = int'(reg_addr_i[2:0]);
        d   = int'(reg_wdata_i);
        if (idx < NO) begin
          case (f)
            0: hs[idx] = d;
            1: he[idx] = d;
            2: vs[idx] = d;
            3: vd[idx] = d;
            4: begin
              pol[idx] = d[0];
              te[idx]  = d[1];
              if (idx == 0) linv = d[2];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // monitor: pop and compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk("R3 R4 R5", "gpo_o", gpo_o, e.g);
      chk("R7", "line_inv_o", {{(NO-1){1'b0}}, line_inv_o}, {{(NO-1){1'b0}}, e.li});
      chk("R8", "blank_o", {{(NO-1){1'b0}}, blank_o}, {{(NO-1){1'b0}}, e.bl});
    end
  end

  task automatic drive(bit ls, bit fs, bit we, int idx, int fld, int data);
    @(negedge clk_i);
    line_sync_i  = ls;
    frame_sync_i = fs;
    reg_we_i     = we;
    reg_addr_i   = 7'((idx << 3) | fld);
    reg_wdata_i  = 11'(data);
    @(negedge clk_i);
    line_sync_i = 0; frame_sync_i = 0; reg_we_i = 0;
  endtask

  task automatic wr(int idx, int fld, int data);
    drive(0, 0, 1, idx, fld, data);
  endtask

  task automatic cfg(int idx, int h0, int h1, int v0, int vdn, int ctl);
    wr(idx, 0, h0); wr(idx, 1, h1); wr(idx, 2, v0); wr(idx, 3, vdn); wr(idx, 4, ctl);
  endtask

  task automatic run_line(bit fs, int ppl);
    drive(!fs, fs, 0, 0, 0, 0);
    repeat (ppl - 2) @(negedge clk_i);
  endtask

  task automatic run_frames(int n, int lines, int ppl);
    for (int f = 0; f < n; f++)
      for (int l = 0; l < lines; l++) run_line(l == 0, ppl);
  endtask

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 200000) begin
      tests_run++;
      tests_failed++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 200000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic s2[4];
    logic s4[4];
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", "gpo_o in reset", gpo_o, '0);
    chk("R1", "line_inv_o in reset", {9'b0, line_inv_o}, '0);
    chk("R1", "blank_o in reset", {9'b0, blank_o}, 10'd1);
    rst_ni = 1'b1;

    phase = "R3";
    cfg(1, 3, 8, 1, 2, 0);        // R3 plain window
    cfg(3, 0, 20, 2, 4, 1);       // R4 active low
    cfg(2, 0, 0, 0, 3, 2);        // R5 R6 alternating, odd span
    cfg(4, 0, 0, 0, 2, 2);        // R6 alternating, even span
    cfg(0, 0, 5, 0, 8, 4);        // R7 window opens at pixel 0
    cfg(9, 2, 18, 0, 6, 0);       // R8 blanking window
    cfg(5, 4, 9, 3, 1, 3);        // R4 R5 alternating + active low
    run_frames(2, 8, 20);

    // R6: sample level at line 0 of consecutive frames
    phase = "R6";
    for (int f = 0; f < 4; f++) begin
      for (int l = 0; l < 8; l++) begin
        run_line(l == 0, 20);
        if (l == 0) begin
          s2[f] = gpo_o[2];
          s4[f] = gpo_o[4];
        end
      end
    end
    for (int f = 1; f < 4; f++) begin
      chk("R6", "odd span frame swap", {9'b0, s2[f]}, {9'b0, ~s2[f-1]});
      chk("R6", "even span frame hold", {9'b0, s4[f]}, {9'b0, s4[f-1]});
    end

    // R9: writes coinciding with line starts, and ignored writes
    phase = "R9";
    drive(1, 0, 1, 1, 0, 0);      // hstart of strobe 1 in same cycle as line sync
    repeat (10) @(negedge clk_i);
    drive(0, 1, 1, 0, 4, 0);      // clear line-inversion enable on frame start
    repeat (10) @(negedge clk_i);
    drive(1, 0, 1, 0, 4, 4);
    wr(12, 0, 1);                 // index out of range
    wr(15, 4, 3);
    wr(1, 7, 0);                  // unused field code
    wr(9, 5, 0);
    run_frames(2, 8, 20);

    // R10: frame sync mid-line, and both syncs together; R2 counter paths
    phase = "R10";
    run_line(0, 20);
    run_line(0, 7);
    drive(1, 1, 0, 0, 0, 0);
    repeat (5) @(negedge clk_i);
    run_line(1, 11);
    phase = "R2";
    run_frames(1, 12, 25);

    repeat (4) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule